// File: doc/BRIEF.md
# Direct-mapped instruction TLB

This block holds the address translations used by instruction fetch. It has 64 entries in a single way. A fetch presents a 32-bit virtual address with an enable. On the next clock edge the block reports whether the entry selected by that address holds a valid translation for it. With that report it gives the physical page number, the user and supervisor execute permissions, and a cache-inhibit attribute.

Software fills and inspects the entries through a register port with a select, a write strobe, a 16-bit address and 32-bit write and read data. Each entry has two halves, and each half sits in its own address window. The match half holds the virtual tag and the valid flag. The translate half holds the physical page and the attributes. While the register port is selected, no lookup completes, so the fetch logic around the block never acts on a translation that software is changing at that moment.

The page size is 8 KiB. Address bits [12:0] are the page offset and are not used here. Bits [18:13] select the entry, and bits [31:19] are compared with the 13-bit tag stored in that entry.

Top module: `itlb_direct`

## Requirements
- R1: While reset is asserted, and right after it, every entry is invalid and every output is zero. A lookup after reset misses even when its tag bits are zero.
- R2: The entry index is `lkp_vaddr[18:13]` and the compared tag is `lkp_vaddr[31:19]`. All 64 entries can be written and then hit independently.
- R3: `lkp_done` is high on the edge after a cycle in which `lkp_en` is high and `cfg_sel` is low. `lkp_hit` is high only in such a cycle, and only when the indexed entry is valid and its tag equals `lkp_vaddr[31:19]`.
- R4: On that same edge, `lkp_ppn`, `lkp_uxe`, `lkp_sxe` and `lkp_ci` take the indexed entry's values, whether or not the lookup hits. They hold their values through every cycle with no completed lookup.
- R5: When `cfg_sel` is high, `lkp_done` and `lkp_hit` are low on the next edge and the result fields keep their values, even if `lkp_en` is high.
- R6: The match word of entry i sits at address 0x1200+i. The tag is in bits [31:19] and the valid flag in bit 0. All other bits read as zero, and writing them has no effect.
- R7: The translate word of entry i sits at address 0x1300+i. The physical page is in bits [31:13], user execute in bit 7, supervisor execute in bit 6 and cache inhibit in bit 1. All other bits read as zero.
- R8: A write with `cfg_sel` and `cfg_wr` both high updates only the addressed half of the addressed entry. A read issued in the next cycle already returns the new value.
- R9: A read (`cfg_sel` high, `cfg_wr` low) returns the addressed word on `cfg_rdata` one edge later. In every cycle after one with no read, `cfg_rdata` is zero.
- R10: An address outside both windows reads as zero, and writing it changes no entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lkp_en | input | 1 | Lookup request |
| lkp_vaddr | input | 32 | Virtual fetch address |
| lkp_done | output | 1 | A lookup completed on this edge |
| lkp_hit | output | 1 | The completed lookup found a valid, matching entry |
| lkp_ppn | output | 19 | Physical page number of the indexed entry |
| lkp_uxe | output | 1 | User-mode execute allowed |
| lkp_sxe | output | 1 | Supervisor-mode execute allowed |
| lkp_ci | output | 1 | Cache-inhibit attribute |
| cfg_sel | input | 1 | Register port select |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 16 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, one cycle after the read |

## Verification
The bound checker watches the timing rules on every cycle. A selected register port suppresses completion and hit. An unselected lookup always completes. A hit never appears without completion. The result fields hold whenever no lookup completes. The read data is zero after writes and idle cycles, and the unused word bits are always zero. Whether a hit is correct, what value a read returns, which bits pack into which word, the isolation between the two halves, and the out-of-window behaviour all depend on stored contents. Only the bench scenarios show these, by comparing against a model of the entries.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
    localparam int unsigned DEF_VA_W       = 32;
    localparam int unsigned DEF_PAGE_BITS  = 13;
    localparam int unsigned DEF_ENTRIES    = 64;
    localparam int unsigned DEF_CFG_AW     = 16;

    // Bit positions inside the software-visible words
    localparam int unsigned VALID_BIT = 0;
    localparam int unsigned CI_BIT    = 1;
    localparam int unsigned SXE_BIT   = 6;
    localparam int unsigned UXE_BIT   = 7;
endpackage

// File: rtl/itlb_va_split.sv
module itlb_va_split #(
    parameter int unsigned VA_W      = 32,
    parameter int unsigned PAGE_BITS = 13,
    parameter int unsigned IDX_W     = 6,
    localparam int unsigned TAG_W    = VA_W - PAGE_BITS - IDX_W
) (
    input  logic [VA_W-PAGE_BITS-1:0] vpn,
    output logic [IDX_W-1:0]          idx,
    output logic [TAG_W-1:0]          tag
);
    // Low VPN bits select the entry, high VPN bits are the compared tag
    assign idx = vpn[IDX_W-1:0];
    assign tag = vpn[VA_W-PAGE_BITS-1 -: TAG_W];
endmodule

// File: rtl/itlb_cfg_decode.sv
module itlb_cfg_decode #(
    parameter int unsigned           ADDR_W     = 16,
    parameter int unsigned           IDX_W      = 6,
    parameter logic [ADDR_W-1:0]     MATCH_BASE = 16'h1200,
    parameter logic [ADDR_W-1:0]     XLAT_BASE  = 16'h1300
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_match,
    output logic              in_xlat,
    output logic [IDX_W-1:0]  idx
);
    // Window bases are aligned to the entry count
    assign in_match = (addr[ADDR_W-1:IDX_W] == MATCH_BASE[ADDR_W-1:IDX_W]);
    assign in_xlat  = (addr[ADDR_W-1:IDX_W] == XLAT_BASE[ADDR_W-1:IDX_W]);
    assign idx      = addr[IDX_W-1:0];
endmodule

// File: rtl/itlb_entry_array.sv
module itlb_entry_array #(
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned TAG_W   = 13,
    parameter int unsigned PPN_W   = 19,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    // write side, one half at a time
    input  logic             wr_match,
    input  logic             wr_xlat,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_valid,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic             wr_uxe,
    input  logic             wr_sxe,
    input  logic             wr_ci,
    // lookup read port
    input  logic [IDX_W-1:0] lk_idx,
    output logic             lk_valid,
    output logic [TAG_W-1:0] lk_tag,
    output logic [PPN_W-1:0] lk_ppn,
    output logic             lk_uxe,
    output logic             lk_sxe,
    output logic             lk_ci,
    // software read port
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [PPN_W-1:0] rd_ppn,
    output logic             rd_uxe,
    output logic             rd_sxe,
    output logic             rd_ci
);
    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0][TAG_W-1:0] tag;
        logic [ENTRIES-1:0][PPN_W-1:0] ppn;
        logic [ENTRIES-1:0]            uxe;
        logic [ENTRIES-1:0]            sxe;
        logic [ENTRIES-1:0]            ci;
    } store_t;

    store_t store_d, store_q;

    always_comb begin
        store_d = store_q;
        if (wr_match) begin
            store_d.valid[wr_idx] = wr_valid;
            store_d.tag[wr_idx]   = wr_tag;
        end
        if (wr_xlat) begin
            store_d.ppn[wr_idx] = wr_ppn;
            store_d.uxe[wr_idx] = wr_uxe;
            store_d.sxe[wr_idx] = wr_sxe;
            store_d.ci[wr_idx]  = wr_ci;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) store_q <= '0;
        else        store_q <= store_d;
    end

    assign lk_valid = store_q.valid[lk_idx];
    assign lk_tag   = store_q.tag[lk_idx];
    assign lk_ppn   = store_q.ppn[lk_idx];
    assign lk_uxe   = store_q.uxe[lk_idx];
    assign lk_sxe   = store_q.sxe[lk_idx];
    assign lk_ci    = store_q.ci[lk_idx];

    assign rd_valid = store_q.valid[rd_idx];
    assign rd_tag   = store_q.tag[rd_idx];
    assign rd_ppn   = store_q.ppn[rd_idx];
    assign rd_uxe   = store_q.uxe[rd_idx];
    assign rd_sxe   = store_q.sxe[rd_idx];
    assign rd_ci    = store_q.ci[rd_idx];
endmodule

// File: rtl/itlb_direct.sv
module itlb_direct #(
    parameter int unsigned             VA_W       = itlb_pkg::DEF_VA_W,
    parameter int unsigned             PAGE_BITS  = itlb_pkg::DEF_PAGE_BITS,
    parameter int unsigned             ENTRIES    = itlb_pkg::DEF_ENTRIES,
    parameter int unsigned             CFG_AW     = itlb_pkg::DEF_CFG_AW,
    parameter logic [CFG_AW-1:0]       MATCH_BASE = 16'h1200,
    parameter logic [CFG_AW-1:0]       XLAT_BASE  = 16'h1300,
    localparam int unsigned            IDX_W      = $clog2(ENTRIES),
    localparam int unsigned            TAG_W      = VA_W - PAGE_BITS - IDX_W,
    localparam int unsigned            PPN_W      = VA_W - PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lkp_en,
    input  logic [VA_W-1:0]   lkp_vaddr,
    output logic              lkp_done,
    output logic              lkp_hit,
    output logic [PPN_W-1:0]  lkp_ppn,
    output logic              lkp_uxe,
    output logic              lkp_sxe,
    output logic              lkp_ci,
    input  logic              cfg_sel,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [VA_W-1:0]   cfg_wdata,
    output logic [VA_W-1:0]   cfg_rdata
);
    import itlb_pkg::*;

    typedef struct packed {
        logic             done;
        logic             hit;
        logic [PPN_W-1:0] ppn;
        logic             uxe;
        logic             sxe;
        logic             ci;
        logic [VA_W-1:0]  rdata;
    } out_t;

    out_t st_d, st_q;

    logic [IDX_W-1:0] va_idx, cfg_idx;
    logic [TAG_W-1:0] va_tag;
    logic             in_match, in_xlat;
    logic             wr_match, wr_xlat;
    logic             lk_valid, rd_valid;
    logic [TAG_W-1:0] lk_tag, rd_tag;
    logic [PPN_W-1:0] lk_ppn, rd_ppn;
    logic             lk_uxe, lk_sxe, lk_ci, rd_uxe, rd_sxe, rd_ci;
    logic             unused_bits;

    assign unused_bits = ^{lkp_vaddr[PAGE_BITS-1:0], cfg_wdata};

    itlb_va_split #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W)) u_split (
        .vpn (lkp_vaddr[VA_W-1:PAGE_BITS]),
        .idx (va_idx),
        .tag (va_tag)
    );

    itlb_cfg_decode #(
        .ADDR_W(CFG_AW), .IDX_W(IDX_W), .MATCH_BASE(MATCH_BASE), .XLAT_BASE(XLAT_BASE)
    ) u_dec (
        .addr     (cfg_addr),
        .in_match (in_match),
        .in_xlat  (in_xlat),
        .idx      (cfg_idx)
    );

    assign wr_match = cfg_sel & cfg_wr & in_match;
    assign wr_xlat  = cfg_sel & cfg_wr & in_xlat;

    itlb_entry_array #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_match (wr_match),
        .wr_xlat  (wr_xlat),
        .wr_idx   (cfg_idx),
        .wr_tag   (cfg_wdata[VA_W-1 -: TAG_W]),
        .wr_valid (cfg_wdata[VALID_BIT]),
        .wr_ppn   (cfg_wdata[VA_W-1 -: PPN_W]),
        .wr_uxe   (cfg_wdata[UXE_BIT]),
        .wr_sxe   (cfg_wdata[SXE_BIT]),
        .wr_ci    (cfg_wdata[CI_BIT]),
        .lk_idx   (va_idx),
        .lk_valid (lk_valid),
        .lk_tag   (lk_tag),
        .lk_ppn   (lk_ppn),
        .lk_uxe   (lk_uxe),
        .lk_sxe   (lk_sxe),
        .lk_ci    (lk_ci),
        .rd_idx   (cfg_idx),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_ppn   (rd_ppn),
        .rd_uxe   (rd_uxe),
        .rd_sxe   (rd_sxe),
        .rd_ci    (rd_ci)
    );

    always_comb begin
        logic go;
        logic rd;
        st_d = st_q;
        // a selected register port blocks lookup completion
        go        = lkp_en & ~cfg_sel;
        st_d.done = go;
        st_d.hit  = go & lk_valid & (lk_tag == va_tag);
        if (go) begin
            st_d.ppn = lk_ppn;
            st_d.uxe = lk_uxe;
            st_d.sxe = lk_sxe;
            st_d.ci  = lk_ci;
        end
        rd         = cfg_sel & ~cfg_wr;
        st_d.rdata = '0;
        if (rd && in_match) begin
            st_d.rdata[VA_W-1 -: TAG_W] = rd_tag;
            st_d.rdata[VALID_BIT]       = rd_valid;
        end else if (rd && in_xlat) begin
            st_d.rdata[VA_W-1 -: PPN_W] = rd_ppn;
            st_d.rdata[UXE_BIT]         = rd_uxe;
            st_d.rdata[SXE_BIT]         = rd_sxe;
            st_d.rdata[CI_BIT]          = rd_ci;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lkp_done  = st_q.done;
    assign lkp_hit   = st_q.hit;
    assign lkp_ppn   = st_q.ppn;
    assign lkp_uxe   = st_q.uxe;
    assign lkp_sxe   = st_q.sxe;
    assign lkp_ci    = st_q.ci;
    assign cfg_rdata = st_q.rdata;
endmodule

// File: rtl/itlb_direct_chk.sv
module itlb_direct_chk #(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned PPN_W = 19
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lkp_en,
    input logic             lkp_done,
    input logic             lkp_hit,
    input logic [PPN_W-1:0] lkp_ppn,
    input logic             lkp_uxe,
    input logic             lkp_sxe,
    input logic             lkp_ci,
    input logic             cfg_sel,
    input logic             cfg_wr,
    input logic [VA_W-1:0]  cfg_rdata
);
    p_sel_blocks_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sel |=> (!lkp_done && !lkp_hit));

    p_lookup_completes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_en && !cfg_sel) |=> lkp_done);

    p_hit_needs_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_hit |-> lkp_done);

    p_results_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(lkp_en && !cfg_sel) |=> ($stable(lkp_ppn) && $stable(lkp_uxe)
                                   && $stable(lkp_sxe) && $stable(lkp_ci)));

    p_rdata_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_sel || cfg_wr) |=> (cfg_rdata == '0));

    p_unused_bits_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[12:8] == 5'd0) && (cfg_rdata[5:2] == 4'd0));
endmodule

bind itlb_direct itlb_direct_chk #(.VA_W(VA_W), .PPN_W(PPN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lkp_en    (lkp_en),
    .lkp_done  (lkp_done),
    .lkp_hit   (lkp_hit),
    .lkp_ppn   (lkp_ppn),
    .lkp_uxe   (lkp_uxe),
    .lkp_sxe   (lkp_sxe),
    .lkp_ci    (lkp_ci),
    .cfg_sel   (cfg_sel),
    .cfg_wr    (cfg_wr),
    .cfg_rdata (cfg_rdata)
);

// File: tb/itlb_direct_bench.sv
`timescale 1ns/1ps
module itlb_direct_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lkp_en = 1'b0;
    logic [31:0] lkp_vaddr = '0;
    logic        lkp_done, lkp_hit, lkp_uxe, lkp_sxe, lkp_ci;
    logic [18:0] lkp_ppn;
    logic        cfg_sel = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;

    always #2.5 clk = ~clk;

    itlb_direct u_itlb_direct (.*);

    typedef struct {
        int          due;
        bit          is_lk;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    finished = 0;

    // reference model of the entries
    logic [12:0] m_tag [64];
    logic        m_valid [64];
    logic [18:0] m_ppn [64];
    logic        m_uxe [64], m_sxe [64], m_ci [64];
    logic [18:0] e_ppn = '0;
    logic        e_uxe = 0, e_sxe = 0, e_ci = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] lk_pack();
        return {lkp_hit, lkp_done, lkp_uxe, lkp_sxe, lkp_ci, 8'b0, lkp_ppn};
    endfunction

    function automatic logic [31:0] match_word(int i);
        return {m_tag[i], 18'b0, m_valid[i]};
    endfunction

    function automatic logic [31:0] xlat_word(int i);
        return {m_ppn[i], 5'b0, m_uxe[i], m_sxe[i], 4'b0, m_ci[i], 1'b0};
    endfunction

    task automatic check(logic [31:0] act, logic [31:0] exp, string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: compare results as they come out
    always @(posedge clk) begin
        item_t it;
        #1;
        while (q.size() > 0 && q[0].due == cyc) begin
            it = q.pop_front();
            check(it.is_lk ? lk_pack() : cfg_rdata, it.exp, it.req);
        end
    end

    // driver: one cycle of stimulus, expected results pushed
    task automatic step(bit en, logic [31:0] va, bit sel, bit wr,
                        logic [15:0] addr, logic [31:0] wd, string req);
        bit          go, hit;
        int          idx, ai;
        logic [31:0] rexp;
        @(negedge clk);
        lkp_en = en; lkp_vaddr = va; cfg_sel = sel; cfg_wr = wr;
        cfg_addr = addr; cfg_wdata = wd;
        go  = en && !sel;
        idx = int'(va[18:13]);
        hit = go && m_valid[idx] && (m_tag[idx] == va[31:19]);
        if (go) begin
            e_ppn = m_ppn[idx]; e_uxe = m_uxe[idx]; e_sxe = m_sxe[idx]; e_ci = m_ci[idx];
        end
        q.push_back('{cyc + 1, 1'b1,
                      {hit, go, e_uxe, e_sxe, e_ci, 8'b0, e_ppn}, req});
        ai   = int'(addr[5:0]);
        rexp = '0;
        if (sel && !wr && addr[15:6] == 10'h048) rexp = match_word(ai);
        else if (sel && !wr && addr[15:6] == 10'h04C) rexp = xlat_word(ai);
        q.push_back('{cyc + 1, 1'b0, rexp, req});
        if (sel && wr && addr[15:6] == 10'h048) begin
            m_tag[ai] = wd[31:19]; m_valid[ai] = wd[0];
        end else if (sel && wr && addr[15:6] == 10'h04C) begin
            m_ppn[ai] = wd[31:13]; m_uxe[ai] = wd[7]; m_sxe[ai] = wd[6]; m_ci[ai] = wd[1];
        end
    endtask

    task automatic wr_reg(logic [15:0] a, logic [31:0] d, string req);
        step(0, '0, 1, 1, a, d, req);
    endtask
    task automatic rd_reg(logic [15:0] a, string req);
        step(0, '0, 1, 0, a, '0, req);
    endtask
    task automatic lookup(logic [31:0] va, string req);
        step(1, va, 0, 0, '0, '0, req);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            m_tag[i] = '0; m_valid[i] = 0; m_ppn[i] = '0;
            m_uxe[i] = 0; m_sxe[i] = 0; m_ci[i] = 0;
        end
        #12;
        // R1: outputs during reset
        check(lk_pack(), 32'h0, "R1 lookup outputs in reset");
        check(cfg_rdata, 32'h0, "R1 rdata in reset");
        @(negedge clk);
        rst_n = 1'b1;
        check(lk_pack(), 32'h0, "R1 lookup outputs after reset");
        // R1: all entries invalid, zero-tag lookup misses
        lookup(32'h0000_0000, "R1 zero-tag lookup misses");
        for (int i = 0; i < 64; i += 9) rd_reg(16'h1200 + 16'(i), "R1 valid clear");

        // R6 R7: program entry 5
        wr_reg(16'h1205, {13'h1ABC, 18'h0, 1'b1}, "R8 match write");
        wr_reg(16'h1305, {19'h5A5A5, 5'h0, 1'b1, 1'b0, 4'h0, 1'b1, 1'b0}, "R8 xlat write");
        // R2 R3 R4: hit
        lookup({13'h1ABC, 6'd5, 13'h0123}, "R3 hit entry 5");
        // R3: tag mismatch misses but fields still load (R4)
        lookup({13'h0ABC, 6'd5, 13'h1FFF}, "R4 miss loads fields");
        lookup({13'h1ABC, 6'd6, 13'h0000}, "R3 invalid neighbour misses");
        lookup({13'h1ABC, 6'd5, 13'h0000}, "R3 hit again");
        // R5: select blocks completion, with and without a read
        step(1, {13'h1ABC, 6'd5, 13'h0}, 1, 0, 16'h1205, '0, "R5 sel with read");
        step(1, {13'h1ABC, 6'd6, 13'h0}, 1, 1, 16'h1100, 32'hFFFF_FFFF, "R5 sel with write");
        step(0, '0, 0, 0, '0, '0, "R4 idle holds fields");
        step(0, '0, 0, 0, 16'h1205, '0, "R9 unselected gives zero");

        // R6: unimplemented match bits
        wr_reg(16'h1209, 32'hFFFF_FFFF, "R6 match all ones");
        rd_reg(16'h1209, "R6 match readback");
        // R7: unimplemented translate bits
        wr_reg(16'h1309, 32'hFFFF_FFFF, "R7 xlat all ones");
        rd_reg(16'h1309, "R7 xlat readback");
        // R8: match write leaves translate intact; read right after write
        wr_reg(16'h1209, 32'h0000_0000, "R8 match clear");
        rd_reg(16'h1309, "R8 xlat untouched");
        rd_reg(16'h1209, "R8 match updated");
        wr_reg(16'h1305, 32'h0000_0000, "R8 xlat clear");
        rd_reg(16'h1205, "R8 match untouched");

        // R10: outside both windows
        wr_reg(16'h1240, 32'hFFFF_FFFF, "R10 write past window");
        wr_reg(16'h12FF, 32'hFFFF_FFFF, "R10 write 12FF");
        wr_reg(16'h11C0, 32'hFFFF_FFFF, "R10 write below");
        wr_reg(16'h1340, 32'hFFFF_FFFF, "R10 write past xlat");
        rd_reg(16'h1240, "R10 read past window");
        rd_reg(16'h1340, "R10 read past xlat");
        rd_reg(16'h1200, "R10 entry 0 unchanged");
        rd_reg(16'h1300, "R10 entry 0 xlat unchanged");
        lookup({13'h1FFF, 6'd0, 13'h0}, "R10 no entry made valid");

        // R2: fill every entry and hit each
        for (int i = 0; i < 64; i++) begin
            wr_reg(16'h1200 + 16'(i), {13'((i * 37 + 1) % 8192), 18'h0, 1'b1}, "R2 fill match");
            wr_reg(16'h1300 + 16'(i), {19'(i * 1237 + 5), 5'h0, 1'(i), 1'(i >> 1),
                                       4'h0, 1'(i >> 2), 1'b0}, "R2 fill xlat");
        end
        for (int i = 0; i < 64; i++)
            lookup({13'((i * 37 + 1) % 8192), 6'(i), 13'(i * 71)}, "R2 hit every entry");
        // R3: invalidate one entry
        wr_reg(16'h1214, 32'h0000_0000, "R3 invalidate 20");
        lookup({13'((20 * 37 + 1) % 8192), 6'd20, 13'h0}, "R3 invalidated misses");
        lookup({13'((21 * 37 + 1) % 8192), 6'd21, 13'h0}, "R3 neighbour still hits");
        step(0, '0, 0, 0, '0, '0, "R9 drain");
        repeat (3) @(negedge clk);
        if (q.size() != 0) check(32'(q.size()), 32'h0, "R9 results not all produced");
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule